// File: doc/BRIEF.md
# Frame Interrupt Coalescer

This block sits between a DMA engine's per-frame completion pulses and the chip's interrupt controller. It stands for one direction, transmit or receive. When coalescing is enabled, it does not forward every completion pulse. It holds them back and raises a single one-cycle interrupt in two cases: when the number of frames gathered in the current interval reaches a programmed frame threshold, or when a timeout expires, whichever happens first. The timeout is measured in units of 64 cycles of a selectable time base. The timer starts only when the first frame of an interval arrives, so an idle link never produces interrupts.

Configuration comes from one 32-bit word. Bit 31 enables coalescing. Bit 30 selects the timer's time base: 1 counts every core clock cycle, and 0 counts pulses on a reference strobe input. Bits [27:20] hold the frame threshold and bits [15:0] hold the timeout in 64-cycle units. A threshold of 0 acts as 1. A delay of d microseconds on a time base of f Hz is programmed as (d × f) / 64e6.

The control is a three-state machine:
- **BYPASS**: coalescing is off.
- **IDLE**: enabled, with nothing pending.
- **PEND**: enabled, with at least one frame gathered and the timer running.

Its transitions are:
- **any→BYPASS** when bit 31 is clear.
- **BYPASS/IDLE→PEND** on a frame that does not reach the threshold.
- **BYPASS/IDLE→IDLE** on a frame that reaches it at once.
- **PEND→IDLE** on a fire with no new frame.
- **PEND→PEND (carry)** on a timeout fire in a cycle that also brings a frame.

Top module: `irq_coalescer`

## Requirements
- R1: With bit 31 of `cfg_word` clear, `irq_out` equals `frame_evt` in the same cycle, and the frame count and timer are discarded.
- R2: The fields are decoded as follows: bit 31 is enable, bit 30 is time-base select (1 = core clock, 0 = `ref_tick` pulses), [27:20] is the frame threshold and [15:0] is the timeout in 64-tick units.
- R3: When enabled with frame threshold N, `irq_out` pulses for one cycle, combinationally, in the cycle that carries the Nth frame of the interval.
- R4: A frame threshold of 0 behaves as 1: every frame fires at once. A timeout of 0 behaves as 1.
- R5: While no frame is pending, the timer holds at zero and no interrupt is raised.
- R6: With the core clock selected and timeout T, a lone frame in cycle t0 fires `irq_out` in cycle t0 + 64·T.
- R7: With bit 30 clear, the timer advances only on `ref_tick` pulses: 64 pulses make one unit.
- R8: Frames arriving while the timer runs do not restart it. The interrupt fires at whichever limit comes first.
- R9: A fire clears both the frame count and the timer in the same cycle. A frame arriving in a timeout-fire cycle counts as 1 toward the next interval.
- R10: Disabling while frames are pending drops them. After re-enabling, no stale timeout fires and a full threshold of new frames is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Coalescing configuration word |
| ref_tick | input | 1 | Reference time-base strobe, one pulse per reference clock cycle |
| frame_evt | input | 1 | Frame-complete pulse from the DMA side |
| irq_out | output | 1 | Coalesced interrupt pulse |

## Verification
The bench targets the exact fire cycle of the timeout: a prescaler off by one, or a timer that starts in the event cycle, would fire a cycle early or late. It drives a frame into the very cycle a timeout fires. A design that drops that frame, or folds it into the finished interval, fires one frame late or early on the next interval. Zero thresholds are programmed to catch a design that never fires or that waits for a counter wrap. A disable/re-enable sequence with frames pending exposes a leftover count or timer as a spurious or premature interrupt.

// File: rtl/irq_coalescer_pkg.sv
package irq_coalescer_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PEND   = 2'd2
    } coal_state_e;

    localparam int CFG_W_DEF     = 32;
    localparam int EN_BIT_DEF    = 31;
    localparam int CS_BIT_DEF    = 30;
    localparam int FRAME_LSB_DEF = 20;
    localparam int FRAME_W_DEF   = 8;
    localparam int TIMER_LSB_DEF = 0;
    localparam int TIMER_W_DEF   = 16;
    localparam int PRESCALE_DEF  = 64;

endpackage

// File: rtl/coal_cfg_decode.sv
module coal_cfg_decode #(
    parameter int CFG_W     = 32,
    parameter int EN_BIT    = 31,
    parameter int CS_BIT    = 30,
    parameter int FRAME_LSB = 20,
    parameter int FRAME_W   = 8,
    parameter int TIMER_LSB = 0,
    parameter int TIMER_W   = 16
) (
    input  logic [CFG_W-1:0]   cfg_word,
    output logic               enable,
    output logic               core_sel,
    output logic [FRAME_W-1:0] frame_thr,
    output logic [TIMER_W-1:0] timer_thr
);
    localparam int FRAME_MSB = FRAME_LSB + FRAME_W - 1;
    localparam int TIMER_MSB = TIMER_LSB + TIMER_W - 1;

    logic [FRAME_W-1:0] frame_raw;
    logic [TIMER_W-1:0] timer_raw;

    assign enable    = cfg_word[EN_BIT];
    assign core_sel  = cfg_word[CS_BIT];
    assign frame_raw = cfg_word[FRAME_MSB:FRAME_LSB];
    assign timer_raw = cfg_word[TIMER_MSB:TIMER_LSB];

    // A zero threshold behaves as one (R4)
    always_comb begin
        frame_thr = (frame_raw == '0) ? FRAME_W'(1) : frame_raw;
        timer_thr = (timer_raw == '0) ? TIMER_W'(1) : timer_raw;
    end

endmodule

// File: rtl/coal_unit_timer.sv
module coal_unit_timer #(
    parameter int PRESCALE = 64,
    parameter int TIMER_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               restart,
    input  logic               src_tick,
    input  logic [TIMER_W-1:0] timer_thr,
    output logic               unit_done,
    output logic               timer_hit
);
    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    logic [PS_W-1:0]    ps_cnt;
    logic [TIMER_W-1:0] unit_cnt;
    logic [TIMER_W:0]   unit_next;

    assign unit_done = active && src_tick && (ps_cnt == PS_LAST);
    assign unit_next = {1'b0, unit_cnt} + 1'b1;
    assign timer_hit = unit_done && (unit_next >= {1'b0, timer_thr});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_cnt   <= '0;
            unit_cnt <= '0;
        end else if (!active || restart) begin
            ps_cnt   <= '0;
            unit_cnt <= '0;
        end else if (src_tick) begin
            if (ps_cnt == PS_LAST) begin
                ps_cnt   <= '0;
                unit_cnt <= unit_next[TIMER_W-1:0];
            end else begin
                ps_cnt <= ps_cnt + 1'b1;
            end
        end
    end

    AST_TIMER_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (ps_cnt == '0) && (unit_cnt == '0)); // R5

    AST_PRESCALE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && !restart) |=> (ps_cnt == '0)); // R6

    AST_NO_TICK_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !restart && !src_tick) |=> $stable(ps_cnt)); // R7

endmodule

// File: rtl/coal_frame_counter.sv
module coal_frame_counter #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               frame_evt,
    input  logic               timer_hit,
    input  logic [FRAME_W-1:0] frame_thr,
    output logic               frame_hit,
    output logic [FRAME_W-1:0] frame_cnt
);
    logic [FRAME_W:0] cnt_inc;

    assign cnt_inc   = {1'b0, frame_cnt} + 1'b1;
    assign frame_hit = enable && frame_evt && (cnt_inc >= {1'b0, frame_thr});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_cnt <= '0;
        end else if (!enable || frame_hit) begin
            frame_cnt <= '0;
        end else if (timer_hit) begin
            frame_cnt <= frame_evt ? FRAME_W'(1) : '0;
        end else if (frame_evt) begin
            frame_cnt <= cnt_inc[FRAME_W-1:0];
        end
    end

    AST_COUNT_HOLDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !frame_evt && !timer_hit) |=> $stable(frame_cnt)); // R8

endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
    import irq_coalescer_pkg::*;
#(
    parameter int CFG_W     = CFG_W_DEF,
    parameter int EN_BIT    = EN_BIT_DEF,
    parameter int CS_BIT    = CS_BIT_DEF,
    parameter int FRAME_LSB = FRAME_LSB_DEF,
    parameter int FRAME_W   = FRAME_W_DEF,
    parameter int TIMER_LSB = TIMER_LSB_DEF,
    parameter int TIMER_W   = TIMER_W_DEF,
    parameter int PRESCALE  = PRESCALE_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             ref_tick,
    input  logic             frame_evt,
    output logic             irq_out
);
    logic               enable;
    logic               core_sel;
    logic [FRAME_W-1:0] frame_thr;
    logic [TIMER_W-1:0] timer_thr;
    logic               src_tick;
    logic               timer_active;
    logic               unit_done;
    logic               timer_hit;
    logic               frame_hit;
    logic               fire;
    logic [FRAME_W-1:0] frame_cnt;

    coal_state_e state_q, state_d;

    coal_cfg_decode #(
        .CFG_W(CFG_W), .EN_BIT(EN_BIT), .CS_BIT(CS_BIT),
        .FRAME_LSB(FRAME_LSB), .FRAME_W(FRAME_W),
        .TIMER_LSB(TIMER_LSB), .TIMER_W(TIMER_W)
    ) u_decode (
        .cfg_word (cfg_word),
        .enable   (enable),
        .core_sel (core_sel),
        .frame_thr(frame_thr),
        .timer_thr(timer_thr)
    );

    assign src_tick     = core_sel ? 1'b1 : ref_tick;
    assign timer_active = enable && (state_q == ST_PEND);
    assign fire         = frame_hit || timer_hit;

    coal_unit_timer #(.PRESCALE(PRESCALE), .TIMER_W(TIMER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (timer_active),
        .restart  (fire),
        .src_tick (src_tick),
        .timer_thr(timer_thr),
        .unit_done(unit_done),
        .timer_hit(timer_hit)
    );

    coal_frame_counter #(.FRAME_W(FRAME_W)) u_frames (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .frame_evt(frame_evt),
        .timer_hit(timer_hit),
        .frame_thr(frame_thr),
        .frame_hit(frame_hit),
        .frame_cnt(frame_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BYPASS;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_BYPASS;
        end else begin
            unique case (state_q)
                ST_BYPASS, ST_IDLE: begin
                    if (frame_evt && !frame_hit) state_d = ST_PEND;
                    else                         state_d = ST_IDLE;
                end
                ST_PEND: begin
                    if (frame_hit)      state_d = ST_IDLE;
                    else if (timer_hit) state_d = frame_evt ? ST_PEND : ST_IDLE;
                    else                state_d = ST_PEND;
                end
                default: state_d = ST_BYPASS;
            endcase
        end
    end

    always_comb begin
        if (enable) irq_out = fire;
        else        irq_out = frame_evt;
    end

    AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_BYPASS) && (frame_cnt == '0)); // R1

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q != ST_PEND && !frame_evt) |-> !irq_out); // R5

    AST_PEND_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_PEND && !frame_evt && !unit_done) |=> (state_q == ST_PEND)); // R8

    AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && fire && !frame_evt) |=> (frame_cnt == '0) && (state_q != ST_PEND)); // R9

    AST_CARRY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_hit && frame_evt && !frame_hit) |=> (frame_cnt == FRAME_W'(1)) && (state_q == ST_PEND)); // R9

endmodule

// File: tb/irq_coalescer_test.sv
module irq_coalescer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        ref_tick = 1'b0;
    logic        frame_evt = 1'b0;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    irq_coalescer uut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .ref_tick(ref_tick), .frame_evt(frame_evt), .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    // R2: bit31 enable, bit30 core-clock select, [27:20] frames, [15:0] timeout
    function automatic logic [31:0] mk_cfg(input logic en, input logic cs,
                                           input int fthr, input int tthr);
        logic [31:0] w;
        w = '0;
        w[31] = en;
        w[30] = cs;
        w[27:20] = fthr[7:0];
        w[15:0] = tthr[15:0];
        return w;
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input int at);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s step %0d: actual=%b expected=%b", req, at, act, exp);
        end
    endtask

    // drive one cycle, return irq sampled mid-cycle
    task automatic step(input logic e, input logic t, output logic irq);
        @(negedge clk);
        frame_evt = e;
        ref_tick = t;
        #1 irq = irq_out;
    endtask

    task automatic idle_gap(input int n);
        logic irq;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, irq);
    endtask

    task automatic test_reset_quiet;
        logic irq;
        cfg_word = mk_cfg(1, 1, 4, 1);
        for (int k = 0; k < 100; k++) begin
            step(1'b0, 1'b0, irq);
            check("R5", irq, 1'b0, k);
        end
    endtask

    task automatic test_bypass;
        logic irq;
        cfg_word = mk_cfg(0, 1, 5, 1);
        for (int k = 0; k < 6; k++) begin
            step(k[0], 1'b0, irq);
            check("R1", irq, k[0], k);
        end
        idle_gap(2);
    endtask

    task automatic test_count;
        logic irq;
        cfg_word = mk_cfg(1, 1, 3, 100);
        idle_gap(2);
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 1'b0, irq);
            check("R3", irq, (k == 2 || k == 5), k);
        end
        idle_gap(2);
    endtask

    task automatic test_zero_thr;
        logic irq;
        cfg_word = mk_cfg(1, 1, 0, 100);
        idle_gap(2);
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0, irq);
            check("R4 frame", irq, 1'b1, k);
        end
        step(1'b0, 1'b0, irq);
        check("R4 frame", irq, 1'b0, 4);
        cfg_word = mk_cfg(1, 1, 10, 0);
        idle_gap(2);
        step(1'b1, 1'b0, irq);
        for (int k = 1; k <= 66; k++) begin
            step(1'b0, 1'b0, irq);
            if (k >= 63) check("R4 timer", irq, (k == 64), k);
        end
    endtask

    task automatic test_timeout_core;
        logic irq;
        cfg_word = mk_cfg(1, 1, 10, 2);
        idle_gap(2);
        step(1'b1, 1'b0, irq);
        check("R6", irq, 1'b0, 0);
        for (int k = 1; k <= 130; k++) begin
            step(1'b0, 1'b0, irq);
            if (k == 64 || k >= 126) check("R6", irq, (k == 128), k);
        end
    endtask

    task automatic test_timeout_ref;
        logic irq;
        cfg_word = mk_cfg(1, 0, 10, 1);
        idle_gap(2);
        step(1'b1, 1'b1, irq);
        for (int k = 1; k <= 200; k++) begin
            step(1'b0, (k % 3 == 0), irq);
            if (k == 64 || k >= 189) check("R7", irq, (k == 192), k);
        end
    endtask

    task automatic test_first_wins;
        logic irq;
        cfg_word = mk_cfg(1, 1, 5, 1);
        idle_gap(2);
        for (int k = 0; k <= 66; k++) begin
            step((k == 0 || k == 20 || k == 40), 1'b0, irq);
            if (k == 20 || k == 40 || k >= 62) check("R8", irq, (k == 64), k);
        end
    endtask

    task automatic test_carry;
        logic irq;
        cfg_word = mk_cfg(1, 1, 10, 1);
        idle_gap(2);
        for (int k = 0; k <= 75; k++) begin
            step((k == 0 || k >= 64), 1'b0, irq);
            if (k >= 63) check("R9", irq, (k == 64 || k == 73), k);
        end
        step(1'b0, 1'b0, irq);
        cfg_word = mk_cfg(1, 1, 10, 100);
        idle_gap(2);
    endtask

    task automatic test_disable_drop;
        logic irq;
        cfg_word = mk_cfg(1, 1, 5, 1);
        idle_gap(2);
        step(1'b1, 1'b0, irq);
        step(1'b1, 1'b0, irq);
        cfg_word = mk_cfg(0, 1, 5, 1);
        step(1'b1, 1'b0, irq);
        check("R10 bypass", irq, 1'b1, 0);
        step(1'b0, 1'b0, irq);
        cfg_word = mk_cfg(1, 1, 5, 1);
        for (int k = 0; k < 70; k++) begin
            step(1'b0, 1'b0, irq);
            if (k >= 60) check("R10 stale", irq, 1'b0, k);
        end
        for (int k = 0; k < 5; k++) begin
            step(1'b1, 1'b0, irq);
            check("R10 fresh", irq, (k == 4), k);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset_quiet();
        test_bypass();
        test_count();
        test_zero_thr();
        test_timeout_core();
        test_timeout_ref();
        test_first_wins();
        test_carry();
        test_disable_drop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule